// File: doc/BRIEF.md
# Low-Power Wake-Up Monitor

This block watches for reasons to leave low-power standby and gives the power sequencer one clean wake request. While the sequencer holds `mon_en` high (standby), the monitor follows one of two wake-capable pins, chosen by `pin_sel`. It treats a level change in either direction as a wake candidate. The candidate counts only if the new level stays put for at least `min_len` clock cycles. An RTC alarm or timer event (`rtc_wake`) and an on-request (`on_req`) also wake the device. All three sources merge into one output pulse that lasts a single cycle.

Each raw pin passes through its own synchronizer chain before the selection mux. The reference level is the synchronized level of the selected pin in the last cycle before `mon_en` rises. So a pin that already sits at a non-idle level when standby starts does not cause a wake. After one pulse the monitor stays quiet until `mon_en` falls and rises again.

Top module: `lpwake_monitor`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `wake_pulse` is low.
- R2: While enabled, a low-to-high change on the selected pin that holds for L = max(`min_len`,1) cycles drives `wake_pulse` high after the 2+L-th rising clock edge following the change (2 synchronizer stages plus L cycles of qualification).
- R3: A high-to-low change on the selected pin is qualified in the same way as in R2 and raises `wake_pulse` with the same latency.
- R4: If the selected pin returns to the reference level before L consecutive cycles, no pulse results, and the length count starts again from zero at the next change.
- R5: While `mon_en` is low, no input (pins, `rtc_wake`, `on_req`) can raise `wake_pulse`, and the cycle after `mon_en` was low never carries a pulse.
- R6: `pin_sel` = 0 selects `wake_pins[0]` and `pin_sel` = 1 selects `wake_pins[1]`. Changes on the other pin have no effect.
- R7: While enabled and armed, `rtc_wake` high in a cycle makes `wake_pulse` high in the next cycle.
- R8: While enabled and armed, `on_req` high in a cycle makes `wake_pulse` high in the next cycle.
- R9: `wake_pulse` is never high in two consecutive cycles. After a pulse, no further pulse occurs until `mon_en` has been low for at least one cycle.
- R10: The reference level is the selected synchronized pin level in the last cycle with `mon_en` low. A pin held at a constant level across enable produces no pulse, whether that level is high or low.
- R11: A `min_len` of 0 behaves exactly like a `min_len` of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_en | input | 1 | High while the device is in low-power standby |
| pin_sel | input | SEL_W (1) | Selects which wake pin is monitored |
| wake_pins | input | NUM_PINS (2) | Raw, unsynchronized wake pin levels |
| rtc_wake | input | 1 | RTC alarm/timer wake event, synchronous |
| on_req | input | 1 | Qualified on-request, synchronous |
| min_len | input | CNT_W (8) | Minimum hold time of a new pin level, in cycles |
| wake_pulse | output | 1 | One-cycle wake request to the power FSM |

## Verification
The assertions take for granted that `rtc_wake` and `on_req` are already synchronous to `clk`. They also assume that `pin_sel` and `min_len` change only while `mon_en` is low, because the reference level and the running count belong to one pin and one threshold. The stimulus follows these rules. Configuration is changed only inside a disabled window, and that window lasts long enough for the synchronizers to settle before `mon_en` rises again. Random pin activity, including glitches shorter than the threshold and toggles on the unselected pin, is applied only to the raw pins.

// File: rtl/lpw_pkg.sv
package lpw_pkg;

   // Merged wake sources presented to the pulse stage
   typedef struct packed {
      logic pin_hit;
      logic rtc;
      logic req;
   } lpw_src_t;

   typedef enum logic {
      LPW_ARMED = 1'b1,
      LPW_SPENT = 1'b0
   } lpw_arm_e;

endpackage

// File: rtl/lpw_sync.sv
module lpw_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   generate
      genvar s;
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= 1'b0;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/lpw_level_qual.sv
module lpw_level_qual #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             level,
   input  logic [CNT_W-1:0] min_len,
   output logic             hit
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic             ref_q;
   logic [CNT_W-1:0] run_q;
   logic [CNT_W-1:0] eff_len;
   logic [CNT_W-1:0] thr;
   logic             differs;

   assign eff_len = (min_len == '0) ? CNT_ONE : min_len;
   assign thr     = eff_len - CNT_ONE;
   assign differs = level ^ ref_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q <= 1'b0;
         run_q <= '0;
      end else if (!enable) begin
         ref_q <= level;
         run_q <= '0;
      end else if (!differs) begin
         run_q <= '0;
      end else if (run_q != CNT_MAX) begin
         run_q <= run_q + CNT_ONE;
      end
   end

   assign hit = enable && differs && (run_q >= thr);
endmodule

// File: rtl/lpw_wake_merge.sv
module lpw_wake_merge
   import lpw_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     enable,
   input  lpw_src_t src,
   output logic     wake_pulse
);
   lpw_arm_e arm_q;
   logic     any_src;
   logic     fire;

   assign any_src = src.pin_hit | src.rtc | src.req;
   assign fire    = enable && (arm_q == LPW_ARMED) && any_src;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q      <= LPW_ARMED;
         wake_pulse <= 1'b0;
      end else begin
         wake_pulse <= fire;
         if (!enable)   arm_q <= LPW_ARMED;
         else if (fire) arm_q <= LPW_SPENT;
      end
   end
endmodule

// File: rtl/lpwake_monitor.sv
module lpwake_monitor
   import lpw_pkg::*;
#(
   parameter int NUM_PINS    = 2,
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 8,
   localparam int SEL_W      = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                mon_en,
   input  logic [SEL_W-1:0]    pin_sel,
   input  logic [NUM_PINS-1:0] wake_pins,
   input  logic                rtc_wake,
   input  logic                on_req,
   input  logic [CNT_W-1:0]    min_len,
   output logic                wake_pulse
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("lpwake_monitor: SYNC_STAGES must be at least 2");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("lpwake_monitor: CNT_W must be at least 2");
      end
      if (NUM_PINS < 2 || NUM_PINS != (1 << SEL_W)) begin : g_bad_pins
         $error("lpwake_monitor: NUM_PINS must be a power of two, at least 2");
      end
   endgenerate

   logic [NUM_PINS-1:0] pins_s;
   logic                sel_level;
   logic                pin_hit;
   lpw_src_t            srcs;

   generate
      genvar p;
      for (p = 0; p < NUM_PINS; p++) begin : g_pin
         lpw_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (wake_pins[p]),
            .q     (pins_s[p])
         );
      end
   endgenerate

   assign sel_level = pins_s[pin_sel];

   lpw_level_qual #(.CNT_W(CNT_W)) u_qual (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (mon_en),
      .level   (sel_level),
      .min_len (min_len),
      .hit     (pin_hit)
   );

   assign srcs.pin_hit = pin_hit;
   assign srcs.rtc     = rtc_wake;
   assign srcs.req     = on_req;

   lpw_wake_merge u_merge (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (mon_en),
      .src        (srcs),
      .wake_pulse (wake_pulse)
   );
endmodule

// File: rtl/lpwake_monitor_chk.sv
module lpwake_monitor_chk (
   input logic clk,
   input logic rst_n,
   input logic mon_en,
   input logic rtc_wake,
   input logic on_req,
   input logic wake_pulse
);
   // Has a pulse been issued since the monitor was last enabled
   logic seen_q;
   logic spent;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       seen_q <= 1'b0;
      else if (!mon_en) seen_q <= 1'b0;
      else              seen_q <= seen_q | wake_pulse;
   end

   assign spent = seen_q | wake_pulse;

   assert_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> $past(mon_en));

   assert_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |=> !wake_pulse);

   assert_no_refire_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && mon_en) |-> !wake_pulse);

   assert_rtc_wakes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_en && rtc_wake && !spent) |=> wake_pulse);

   assert_req_wakes_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_en && on_req && !spent) |=> wake_pulse);
endmodule

bind lpwake_monitor lpwake_monitor_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mon_en     (mon_en),
   .rtc_wake   (rtc_wake),
   .on_req     (on_req),
   .wake_pulse (wake_pulse)
);

// File: tb/lpwake_monitor_tb.sv
`timescale 1ns/1ps
module lpwake_monitor_tb;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mon_en = 1'b0;
   logic [0:0]    pin_sel = 1'b0;
   logic [1:0]    wake_pins = 2'b00;
   logic          rtc_wake = 1'b0;
   logic          on_req = 1'b0;
   logic [CW-1:0] min_len = 8'd1;
   logic          wake_pulse;

   int n_cmp = 0;
   int n_bad = 0;
   string tag = "R1";

   always #2 clk = ~clk;

   lpwake_monitor #(.NUM_PINS(2), .SYNC_STAGES(2), .CNT_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .pin_sel(pin_sel),
      .wake_pins(wake_pins), .rtc_wake(rtc_wake), .on_req(on_req),
      .min_len(min_len), .wake_pulse(wake_pulse)
   );

   // Behavioural expectation built from the requirements
   logic m_a1, m_a2, m_b1, m_b2, m_ref, m_armed, m_exp;
   int   m_run;

   function automatic int eff_len(input int v);
      return (v == 0) ? 1 : v;
   endfunction

   function automatic logic qualifies(input logic lvl, input logic rf,
                                      input int run, input int ml);
      return (lvl != rf) && (run + 1 >= eff_len(ml));
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_a1 <= 0; m_a2 <= 0; m_b1 <= 0; m_b2 <= 0;
         m_ref <= 0; m_armed <= 1; m_exp <= 0; m_run <= 0;
      end else begin
         logic lvl, fire;
         m_a1 <= wake_pins[0]; m_a2 <= m_a1;
         m_b1 <= wake_pins[1]; m_b2 <= m_b1;
         lvl = pin_sel[0] ? m_b2 : m_a2;
         if (!mon_en) begin
            m_ref <= lvl; m_run <= 0; m_armed <= 1; m_exp <= 0;
         end else begin
            fire = m_armed && (qualifies(lvl, m_ref, m_run, int'(min_len)) || rtc_wake || on_req);
            m_run <= (lvl != m_ref) ? m_run + 1 : 0;
            m_exp <= fire;
            if (fire) m_armed <= 0;
         end
      end
   end

   task automatic check(input string req, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: wake_pulse actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   // One clock: pass a rising edge, then compare with the model at the falling edge
   task automatic step();
      @(posedge clk);
      @(negedge clk);
      check(tag, wake_pulse, m_exp);
   endtask

   task automatic steps(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic count_pulses(input int n, output int cnt);
      cnt = 0;
      for (int i = 0; i < n; i++) begin
         step();
         if (wake_pulse) cnt++;
      end
   endtask

   // Disable long enough for the synchronizers to settle, optionally reconfigure, enable
   task automatic rearm(input logic sel, input int ml);
      mon_en = 0;
      pin_sel = sel;
      min_len = CW'(ml);
      steps(4);
      mon_en = 1;
   endtask

   initial begin
      #800000;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int c;
      void'($urandom(32'h5EED_0042));
      // R1 reset
      tag = "R1";
      @(negedge clk); check("R1", wake_pulse, 1'b0);
      steps(2);
      rst_n = 1;
      @(posedge clk); @(negedge clk); check("R1", wake_pulse, 1'b0);

      // R2 rising edge, L=3: pulse after 5th edge
      tag = "R2";
      rearm(1'b0, 3);
      steps(3);
      wake_pins[0] = 1;
      steps(4); check("R2", wake_pulse, 1'b0);
      step();   check("R2", wake_pulse, 1'b1);
      step();   check("R2", wake_pulse, 1'b0);

      // R9 no refire while still enabled
      tag = "R9";
      wake_pins[0] = 0; steps(5); wake_pins[0] = 1; rtc_wake = 1; on_req = 1;
      count_pulses(20, c); check("R9", c != 0, 1'b0);
      rtc_wake = 0; on_req = 0;

      // R3 falling edge, L=3
      tag = "R3";
      rearm(1'b0, 3);
      steps(2);
      wake_pins[0] = 0;
      steps(4); check("R3", wake_pulse, 1'b0);
      step();   check("R3", wake_pulse, 1'b1);
      step();   check("R3", wake_pulse, 1'b0);

      // R4 glitch shorter than L=4, then a valid hold
      tag = "R4";
      rearm(1'b0, 4);
      wake_pins[0] = 1; steps(3); wake_pins[0] = 0;
      count_pulses(12, c); check("R4", c != 0, 1'b0);
      wake_pins[0] = 1;
      steps(5); check("R4", wake_pulse, 1'b0);
      step();   check("R4", wake_pulse, 1'b1);

      // R6 unselected pin ignored, selected pin works
      tag = "R6";
      wake_pins = 2'b01;
      rearm(1'b1, 2);
      wake_pins[0] = 0;
      count_pulses(12, c); check("R6", c != 0, 1'b0);
      wake_pins[1] = 1;
      steps(3); check("R6", wake_pulse, 1'b0);
      step();   check("R6", wake_pulse, 1'b1);

      // R7 RTC wake
      tag = "R7";
      rearm(1'b1, 5);
      steps(2);
      rtc_wake = 1; step(); rtc_wake = 0;
      check("R7", wake_pulse, 1'b1);

      // R8 on-request wake
      tag = "R8";
      rearm(1'b1, 5);
      steps(1);
      on_req = 1; step(); on_req = 0;
      check("R8", wake_pulse, 1'b1);

      // R5 disabled: nothing wakes
      tag = "R5";
      mon_en = 0;
      wake_pins = 2'b10; rtc_wake = 1; on_req = 1; steps(3);
      wake_pins = 2'b01; steps(3);
      count_pulses(10, c); check("R5", c != 0, 1'b0);
      rtc_wake = 0; on_req = 0;

      // R10 constant high level across enable does not wake
      tag = "R10";
      wake_pins = 2'b11;
      rearm(1'b0, 1);
      count_pulses(15, c); check("R10", c != 0, 1'b0);
      wake_pins = 2'b00;
      rearm(1'b0, 1);
      count_pulses(15, c); check("R10", c != 0, 1'b0);

      // R11 min_len 0 acts as 1: pulse after 3rd edge
      tag = "R11";
      rearm(1'b0, 0);
      wake_pins[0] = 1;
      steps(2); check("R11", wake_pulse, 1'b0);
      step();   check("R11", wake_pulse, 1'b1);

      // Random episodes checked cycle by cycle against the model
      tag = "R2/R3/R4/R6/R7/R8/R9";
      for (int e = 0; e < 60; e++) begin
         mon_en = 0;
         pin_sel = 1'($urandom_range(0, 1));
         min_len = CW'($urandom_range(0, 10));
         wake_pins = 2'($urandom_range(0, 3));
         steps(4);
         mon_en = 1;
         for (int k = 0; k < 50; k++) begin
            if ($urandom_range(0, 5) == 0) wake_pins[0] = ~wake_pins[0];
            if ($urandom_range(0, 5) == 0) wake_pins[1] = ~wake_pins[1];
            rtc_wake = ($urandom_range(0, 60) == 0);
            on_req   = ($urandom_range(0, 60) == 0);
            step();
         end
         rtc_wake = 0; on_req = 0;
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule